// File: doc/BRIEF.md
# Dilated Circuit-Switched Crossbar Router

This block is an unqueued, circuit-switched routing switch with eight input channels and eight output channels. Each channel is nine bits wide: a framing bit plus a data byte. A sender opens a connection by raising the framing bit. The low two bits of the first framed word choose one of four directions. In the default mode each direction is served by two equivalent output ports. When both are idle, a free-running pseudo-random source picks one of them. When neither is idle, the whole transmission is absorbed and discarded. When the sender lowers the framing bit, the switch answers with a one-cycle status pulse. The pulse is positive only if the connection was made and the downstream side accepted it.

While a connection is open, the sender can pulse a turn request. The connection then reverses: the downstream back channel is relayed to the sender, and the forward channel carries only the framing bit. A second pulse restores the forward direction. A mode input splits the switch into two independent four-input crossbars. Each half has one output port per direction.

Top module: `rtr_switch`

## Requirements
- R1: Bit 8 of a channel word is the framing bit. A framed word on an idle input is a header, and its bits [1:0] give the direction. The transmission ends at the first word with the framing bit low. A connected input's words appear unchanged on its output port one clock later.
- R2: With mode_split low, direction d is served by ports 2d and 2d+1, and any input may use either of them. An input owns at most one port while connected.
- R3: If only one port of the requested direction is idle, the header takes that port. If none is idle, the transmission is dropped and no output port shows any of its words.
- R4: If both ports of the requested direction are idle, the choice between them is pseudo-random, so repeated identical requests end up on both ports.
- R5: When several headers request the same direction in one cycle, they are served in ascending input index, up to the number of idle ports. Inputs that do not get a port are dropped.
- R6: One clock after the closing word, in_stat_vld pulses for exactly one cycle. in_stat_ok then equals out_ok of the owned port, sampled in the closing cycle, for a connected transmission. It is 0 for a dropped transmission.
- R7: A port is released by the closing word of its owner and may be claimed by a header in the following cycle, but not in the same cycle. An unowned port outputs all-zero words.
- R8: An in_turn pulse on a connected input with the framing bit high toggles the connection direction. While the connection is reversed, the port outputs 9'h100, and in_back carries that port's out_back one clock later. Otherwise in_back is zero. in_turn on an idle or dropped input has no effect.
- R9: With mode_split high, inputs 0-3 use only ports 0-3 and inputs 4-7 use only ports 4-7. Direction d maps to port (group base + d).
- R10: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_split | input | 1 | 1 = two independent four-input crossbars |
| in_word | input | 8x9 | Per-input channel words (bit 8 framing) |
| in_turn | input | 8 | Per-input request to reverse the open connection |
| in_back | output | 8x8 | Data returned to each sender while reversed |
| in_stat_vld | output | 8 | Status pulse after a transmission closes |
| in_stat_ok | output | 8 | Status value: 1 = routed and accepted |
| out_word | output | 8x9 | Per-output channel words |
| out_back | input | 8x8 | Data from downstream, used while reversed |
| out_ok | input | 8 | Downstream acceptance for each port |

## Verification
Suppose a connection register holds a wrong owner or direction flag. Within one clock, that output port shows data from the wrong source, the hold word, or a zero word. Suppose an input's link state is wrong. The status pulse then carries the wrong value one cycle after the closing word, or a transmission that should have been dropped shows up on a port, or the reverse is true. A stale port release would let a later header be granted or blocked one cycle off. That mistake shows up in the very next output word.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_LINK = 2'd1,
    LS_DROP = 2'd2
  } link_st_e;

  // lower-numbered candidate port for a request
  function automatic int first_port(bit split, int src, int dir, int ndir);
    return split ? (src / ndir) * ndir + dir : 2 * dir;
  endfunction

  // higher-numbered candidate port (equal to first_port when split)
  function automatic int second_port(bit split, int src, int dir, int ndir);
    return split ? (src / ndir) * ndir + dir : 2 * dir + 1;
  endfunction

  function automatic int port_group(int idx, int ndir);
    return idx / ndir;
  endfunction

endpackage

// File: rtl/rtr_lfsr.sv
module rtr_lfsr #(
  parameter int W    = 8,
  parameter int TAPS = 'hB8,
  parameter int SEED = 'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAP_V  = W'(TAPS);
  localparam logic [W-1:0] SEED_V = W'(SEED);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED_V;
    else if (state[0]) state <= (state >> 1) ^ TAP_V;
    else state <= state >> 1;
  end
endmodule

// File: rtl/rtr_alloc.sv
module rtr_alloc
  import rtr_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NDIR  = 4,
  parameter int DIR_W = 2,
  parameter int IDX_W = 3
) (
  input  logic                       split,
  input  logic [NCH-1:0]             req,
  input  logic [NCH-1:0][DIR_W-1:0]  dir,
  input  logic [NCH-1:0]             busy,
  input  logic [NCH-1:0]             rnd,
  output logic [NCH-1:0]             grant,
  output logic [NCH-1:0][IDX_W-1:0]  gport,
  output logic [NCH-1:0]             claim,
  output logic [NCH-1:0][IDX_W-1:0]  claim_by
);
  always_comb begin
    logic [NCH-1:0]   taken;
    logic [IDX_W-1:0] lo, hi, pick;
    logic             found;
    taken    = busy;
    grant    = '0;
    gport    = '0;
    claim    = '0;
    claim_by = '0;
    // ascending index = fixed priority
    for (int i = 0; i < NCH; i++) begin
      lo    = IDX_W'(first_port(split, i, int'(dir[i]), NDIR));
      hi    = IDX_W'(second_port(split, i, int'(dir[i]), NDIR));
      pick  = lo;
      found = 1'b0;
      if (req[i]) begin
        if (lo != hi && !taken[lo] && !taken[hi]) begin
          pick  = rnd[i] ? hi : lo;
          found = 1'b1;
        end else if (!taken[lo]) begin
          pick  = lo;
          found = 1'b1;
        end else if (!taken[hi]) begin
          pick  = hi;
          found = 1'b1;
        end
      end
      if (found) begin
        taken[pick]    = 1'b1;
        grant[i]       = 1'b1;
        gport[i]       = pick;
        claim[pick]    = 1'b1;
        claim_by[pick] = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rtr_inport.sv
module rtr_inport
  import rtr_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame,
  input  logic                          grant,
  input  logic [IDX_W-1:0]              gport,
  input  logic [NCH-1:0]                out_ok,
  input  logic [NCH-1:0][BYTE_W-1:0]    out_back,
  input  logic [NCH-1:0]                rev,
  output logic                          req,
  output logic                          linked,
  output logic [IDX_W-1:0]              port,
  output logic                          close_evt,
  output logic                          stat_vld,
  output logic                          stat_ok,
  output logic [BYTE_W-1:0]             back
);
  link_st_e st;

  assign req       = (st == LS_IDLE) && frame;
  assign linked    = (st == LS_LINK);
  assign close_evt = (st != LS_IDLE) && !frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LS_IDLE;
      port     <= '0;
      stat_vld <= 1'b0;
      stat_ok  <= 1'b0;
      back     <= '0;
    end else begin
      stat_vld <= close_evt;
      stat_ok  <= linked && !frame && out_ok[port];
      back     <= (linked && frame && rev[port]) ? out_back[port] : '0;
      unique case (st)
        LS_IDLE: if (frame) begin
          st <= grant ? LS_LINK : LS_DROP;
          if (grant) port <= gport;
        end
        LS_LINK, LS_DROP: if (!frame) st <= LS_IDLE;
        default: st <= LS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtr_outport.sv
module rtr_outport #(
  parameter int NCH    = 8,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        claim,
  input  logic [IDX_W-1:0]            claim_by,
  input  logic [NCH-1:0][BYTE_W:0]    in_word,
  input  logic [NCH-1:0]              in_turn,
  output logic [BYTE_W:0]             out_word,
  output logic                        own_vld,
  output logic [IDX_W-1:0]            own_idx,
  output logic                        rev,
  output logic                        release_evt
);
  localparam logic [BYTE_W:0] HOLD = {1'b1, {BYTE_W{1'b0}}};

  logic own_frame;
  assign own_frame   = in_word[own_idx][BYTE_W];
  assign release_evt = own_vld && !own_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word <= '0;
      own_vld  <= 1'b0;
      own_idx  <= '0;
      rev      <= 1'b0;
    end else if (own_vld) begin
      if (own_frame) begin
        out_word <= rev ? HOLD : in_word[own_idx];
        if (in_turn[own_idx]) rev <= !rev;
      end else begin
        own_vld  <= 1'b0;
        rev      <= 1'b0;
        out_word <= '0;
      end
    end else if (claim) begin
      own_vld  <= 1'b1;
      own_idx  <= claim_by;
      rev      <= 1'b0;
      out_word <= in_word[claim_by];
    end else begin
      out_word <= '0;
    end
  end
endmodule

// File: rtl/rtr_switch.sv
module rtr_switch
  import rtr_pkg::*;
#(
  parameter  int DIR_W     = 2,
  parameter  int BYTE_W    = 8,
  parameter  int LFSR_TAPS = 'hB8,
  parameter  int LFSR_SEED = 'h5A,
  localparam int NDIR      = 1 << DIR_W,
  localparam int NCH       = 2 * NDIR,
  localparam int IDX_W     = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_split,
  input  logic [NCH-1:0][BYTE_W:0]   in_word,
  input  logic [NCH-1:0]             in_turn,
  output logic [NCH-1:0][BYTE_W-1:0] in_back,
  output logic [NCH-1:0]             in_stat_vld,
  output logic [NCH-1:0]             in_stat_ok,
  output logic [NCH-1:0][BYTE_W:0]   out_word,
  input  logic [NCH-1:0][BYTE_W-1:0] out_back,
  input  logic [NCH-1:0]             out_ok
);
  logic [NCH-1:0]            req, grant, claim, own_vld, rev;
  logic [NCH-1:0]            in_linked, close_evt, release_evt;
  logic [NCH-1:0][DIR_W-1:0] req_dir;
  logic [NCH-1:0][IDX_W-1:0] gport, claim_by, own_idx, in_port;
  logic [NCH-1:0]            rnd;

  rtr_lfsr #(.W(NCH), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd)
  );

  rtr_alloc #(.NCH(NCH), .NDIR(NDIR), .DIR_W(DIR_W), .IDX_W(IDX_W)) u_alloc (
    .split(mode_split), .req(req), .dir(req_dir), .busy(own_vld),
    .rnd(rnd), .grant(grant), .gport(gport), .claim(claim),
    .claim_by(claim_by)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_in
    assign req_dir[i] = in_word[i][DIR_W-1:0];
    rtr_inport #(.NCH(NCH), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_in (
      .clk(clk), .rst_n(rst_n), .frame(in_word[i][BYTE_W]),
      .grant(grant[i]), .gport(gport[i]), .out_ok(out_ok),
      .out_back(out_back), .rev(rev), .req(req[i]),
      .linked(in_linked[i]), .port(in_port[i]), .close_evt(close_evt[i]),
      .stat_vld(in_stat_vld[i]), .stat_ok(in_stat_ok[i]), .back(in_back[i])
    );
  end

  for (genvar o = 0; o < NCH; o++) begin : g_out
    rtr_outport #(.NCH(NCH), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_out (
      .clk(clk), .rst_n(rst_n), .claim(claim[o]), .claim_by(claim_by[o]),
      .in_word(in_word), .in_turn(in_turn), .out_word(out_word[o]),
      .own_vld(own_vld[o]), .own_idx(own_idx[o]), .rev(rev[o]),
      .release_evt(release_evt[o])
    );
  end
endmodule

// File: rtl/rtr_chk.sv
module rtr_chk #(
  parameter int NCH    = 8,
  parameter int NDIR   = 4,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mode_split,
  input logic [NCH-1:0]            claim,
  input logic [NCH-1:0]            own_vld,
  input logic [NCH-1:0][IDX_W-1:0] own_idx,
  input logic [NCH-1:0]            release_evt,
  input logic [NCH-1:0][BYTE_W:0]  out_word,
  input logic [NCH-1:0]            in_linked,
  input logic [NCH-1:0][IDX_W-1:0] in_port,
  input logic [NCH-1:0]            close_evt,
  input logic [NCH-1:0]            in_stat_vld
);
  for (genvar o = 0; o < NCH; o++) begin : g_o
    AST_CLAIM_FREE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      claim[o] |-> !own_vld[o]); // R3
    AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_vld[o] && !claim[o]) |=> (out_word[o] == '0)); // R7
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      release_evt[o] |=> (out_word[o] == '0 && !own_vld[o])); // R7
    AST_SPLIT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_split && claim[o]) |=> (int'(own_idx[o]) / NDIR == o / NDIR)); // R9
  end

  for (genvar i = 0; i < NCH; i++) begin : g_i
    AST_LINK_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      in_linked[i] |-> (own_vld[in_port[i]] && own_idx[in_port[i]] == IDX_W'(i))); // R2
    AST_CLOSE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      close_evt[i] |=> in_stat_vld[i]); // R6
    AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_stat_vld[i] |=> !in_stat_vld[i]); // R6
  end
endmodule

bind rtr_switch rtr_chk #(.NCH(NCH), .NDIR(NDIR), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .claim(claim),
  .own_vld(own_vld), .own_idx(own_idx), .release_evt(release_evt),
  .out_word(out_word), .in_linked(in_linked), .in_port(in_port),
  .close_evt(close_evt), .in_stat_vld(in_stat_vld)
);

// File: tb/sim_rtr_switch.sv
module sim_rtr_switch;
  localparam int NCH = 8;
  localparam int NDIR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_split = 1'b0;
  logic [NCH-1:0][8:0] in_word = '0;
  logic [NCH-1:0]      in_turn = '0;
  logic [NCH-1:0][7:0] in_back;
  logic [NCH-1:0]      in_stat_vld, in_stat_ok;
  logic [NCH-1:0][8:0] out_word;
  logic [NCH-1:0][7:0] out_back = '0;
  logic [NCH-1:0]      out_ok = '0;

  always #4 clk = ~clk;

  rtr_switch u0 (
    .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .in_word(in_word),
    .in_turn(in_turn), .in_back(in_back), .in_stat_vld(in_stat_vld),
    .in_stat_ok(in_stat_ok), .out_word(out_word), .out_back(out_back),
    .out_ok(out_ok)
  );

  // reference model state
  int ist[NCH];   // 0 idle, 1 linked, 2 dropping
  int iprt[NCH];
  int own[NCH];
  bit rv[NCH];
  logic [8:0] e_out[NCH];
  logic [7:0] e_back[NCH];
  bit e_sv[NCH], e_sok[NCH];
  int amb_a[NCH], amb_b[NCH];

  // traffic engine
  int ph[NCH], cnt[NCH], tlen[NCH], tdir[NCH], tturn[NCH];
  bit stray[NCH];
  int seq = 0;

  int n_chk = 0, n_bad = 0, pick_lo = 0, pick_hi = 0;
  string req_tag = "R1";
  bit finished = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(bit ok, string r, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      ist[i] = 0; iprt[i] = 0; own[i] = -1; rv[i] = 0; ph[i] = 0;
      e_out[i] = '0; e_back[i] = '0; e_sv[i] = 0; e_sok[i] = 0;
      amb_a[i] = -1; amb_b[i] = -1; stray[i] = 0;
    end
  endtask

  task automatic launch(int i, int d, int l, int t);
    ph[i] = 1; cnt[i] = 0; tlen[i] = l; tdir[i] = d; tturn[i] = t;
    seq++;
  endtask

  task automatic drive();
    for (int i = 0; i < NCH; i++) begin
      in_turn[i] = 1'b0;
      if (ph[i] == 1) begin
        if (cnt[i] <= tlen[i]) begin
          if (cnt[i] == 0) in_word[i] = {1'b1, 3'(i), 3'(seq), 2'(tdir[i])};
          else in_word[i] = {1'b1, 8'($urandom)};
          if (cnt[i] == tturn[i] && cnt[i] > 0) in_turn[i] = 1'b1;
          cnt[i]++;
        end else begin
          in_word[i] = '0;
          ph[i] = 0;
        end
      end else begin
        in_word[i] = '0;
        in_turn[i] = stray[i];
      end
      out_back[i] = 8'($urandom);
      out_ok[i]   = 1'($urandom);
    end
  endtask

  task automatic model_edge();
    int pre[NCH];
    bit taken[NCH];
    int p, a, b, d;
    for (int k = 0; k < NCH; k++) begin
      e_out[k] = '0; e_back[k] = '0; e_sv[k] = 0; e_sok[k] = 0;
      amb_a[k] = -1; amb_b[k] = -1;
      taken[k] = (own[k] >= 0); pre[k] = ist[k];
    end
    for (int i = 0; i < NCH; i++) begin
      if (pre[i] == 1) begin
        p = iprt[i];
        if (in_word[i][8]) begin
          e_out[p] = rv[p] ? 9'h100 : in_word[i];
          if (rv[p]) e_back[i] = out_back[p];
          if (in_turn[i]) rv[p] = !rv[p];
        end else begin
          e_sv[i] = 1; e_sok[i] = out_ok[p];
          own[p] = -1; rv[p] = 0; ist[i] = 0;
        end
      end else if (pre[i] == 2 && !in_word[i][8]) begin
        e_sv[i] = 1; ist[i] = 0;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (pre[i] == 0 && in_word[i][8]) begin
        d = int'(in_word[i][1:0]);
        if (mode_split) begin a = (i / NDIR) * NDIR + d; b = a; end
        else begin a = 2 * d; b = 2 * d + 1; end
        p = -1;
        if (a != b && !taken[a] && !taken[b]) begin
          p = a; amb_a[i] = a; amb_b[i] = b;
        end else if (!taken[a]) p = a;
        else if (!taken[b]) p = b;
        if (p >= 0) begin
          taken[p] = 1; own[p] = i; rv[p] = 0; iprt[i] = p; ist[i] = 1;
          e_out[p] = in_word[i];
        end else ist[i] = 2;
      end
    end
  endtask

  task automatic model_check();
    bit good = 1;
    int a, b, oa, ob;
    logic [8:0] tmp;
    for (int i = 0; i < NCH; i++) begin
      if (amb_a[i] >= 0) begin
        a = amb_a[i]; b = amb_b[i];
        if (out_word[b] === e_out[a] && out_word[a] !== e_out[a]) begin
          oa = own[a]; ob = own[b];
          own[a] = ob; own[b] = oa;
          tmp = e_out[a]; e_out[a] = e_out[b]; e_out[b] = tmp;
          if (ob >= 0) iprt[ob] = a;
          iprt[oa] = b;
          pick_hi++;
        end else pick_lo++;
      end
    end
    n_chk++;
    for (int k = 0; k < NCH; k++) begin
      if (out_word[k] !== e_out[k]) begin
        good = 0;
        $display("FAIL %s out_word[%0d]: actual %h expected %h", req_tag, k, out_word[k], e_out[k]);
      end
      if (in_back[k] !== e_back[k]) begin
        good = 0;
        $display("FAIL %s in_back[%0d]: actual %h expected %h", req_tag, k, in_back[k], e_back[k]);
      end
      if (in_stat_vld[k] !== e_sv[k] || in_stat_ok[k] !== e_sok[k]) begin
        good = 0;
        $display("FAIL %s status[%0d]: actual %b%b expected %b%b", req_tag, k,
                 in_stat_vld[k], in_stat_ok[k], e_sv[k], e_sok[k]);
      end
    end
    if (!good) n_bad++;
  endtask

  task automatic tick();
    drive();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    model_check();
  endtask

  task automatic wait_idle();
    bit busy = 1;
    while (busy) begin
      tick();
      busy = 0;
      for (int i = 0; i < NCH; i++) if (ph[i] != 0) busy = 1;
    end
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10: outputs zero under reset
    check(out_word == '0 && in_back == '0 && in_stat_vld == '0 && in_stat_ok == '0,
          "R10", "outputs in reset", longint'(out_word), 0);
    rst_n = 1'b1;
    tick();

    // R1 R2: single transmission forwarded one cycle late
    req_tag = "R1/R2";
    launch(0, 2, 4, -1);
    wait_idle();

    // R5 R3 R6: three same-direction headers in one cycle
    req_tag = "R5/R3/R6";
    launch(1, 1, 6, -1); launch(2, 1, 6, -1); launch(3, 1, 3, -1);
    wait_idle();

    // R3: one port left, then none
    req_tag = "R3";
    launch(4, 0, 10, -1);
    tick(); tick();
    launch(5, 0, 4, -1); launch(6, 0, 4, -1);
    wait_idle();

    // R7: release takes effect the cycle after the closing word
    req_tag = "R7";
    launch(0, 3, 14, -1);
    tick();
    launch(1, 3, 3, -1);
    repeat (4) tick();
    launch(2, 3, 2, -1);
    tick();
    launch(3, 3, 2, -1);
    wait_idle();

    // R8: reversal, turn on a dropped transmission, stray turn on idle
    req_tag = "R8";
    stray[6] = 1;
    launch(0, 1, 9, 3); launch(5, 1, 8, 2);
    tick();
    launch(2, 1, 4, 2);
    wait_idle();
    launch(3, 2, 8, 2);
    wait_idle();
    stray[6] = 0;

    // R9: split mode groups
    req_tag = "R9";
    mode_split = 1'b1;
    launch(0, 2, 5, -1); launch(4, 2, 5, -1); launch(1, 2, 3, -1);
    launch(7, 0, 4, 2);
    wait_idle();
    mode_split = 1'b0;
    tick();

    // R4: random choice among two idle ports
    req_tag = "R4";
    pick_lo = 0; pick_hi = 0;
    for (int t = 0; t < 64; t++) begin
      launch(3, 2, 1, -1);
      wait_idle();
    end
    check(pick_lo > 0 && pick_hi > 0, "R4", "both ports chosen (lo count, hi count)",
          longint'(pick_lo) * 1000 + pick_hi, 1);

    // R6: random soak, both modes
    req_tag = "R6";
    for (int m = 0; m < 2; m++) begin
      mode_split = 1'(m);
      for (int c = 0; c < 400; c++) begin
        for (int i = 0; i < NCH; i++)
          if (ph[i] == 0 && ist[i] == 0 && ($urandom % 4) == 0)
            launch(i, int'($urandom % 4), int'($urandom % 6), int'($urandom % 5) - 1);
        tick();
      end
      wait_idle();
    end

    summary();
  end
endmodule